// File: doc/BRIEF.md
# Multicontext Coarse-Grained Processing Element

This block is a single processing element for a coarse-grained reconfigurable array. It works on 24-bit words, and each word travels with a 2-bit carry. Inside are an arithmetic unit (add, subtract, multiply, unsigned compare), a shift/mask/constant unit and a four-entry register file. The configuration word chooses the source of every operand, the operation of each unit, the register-file addresses and the source of the result. Nothing is hard-wired.

Configuration words live in a local context memory with 64 slots. A pointer input selects the active slot. The pointer is registered on every clock, so a new value gives the element a completely different datapath one clock later. Slots can be rewritten through a write port while the element runs any context, including the one in use. The context memory is not cleared by reset, so software loads a slot before selecting it.

The datapath has no states. Its "modes" are the enumerated codes of the arithmetic unit (ADD, SUB, MUL, CMP) and of the shift unit (SHL, SHR, AND, CONST), each decoded by a unique case. The selected slot fixes the mode for each cycle. Pointer changes and slot writes are the only transitions.

Top module: `ctx_pe`

## Requirements
- R1: While reset is asserted and afterwards until the first enabled edge, `res_d_o` and `res_cy_o` are zero, and every register-file entry reads as zero.
- R2: The configuration word is 31 bits, listed from MSB to LSB:
  - imm [30:23]
  - alu_op [22:21], coded ADD=0, SUB=1, MUL=2, CMP=3
  - smu_op [20:19], coded SHL=0, SHR=1, AND=2, CONST=3
  - alu_a [18:17] and alu_b [16:15], the ALU operand sources
  - alu_cy [14:13]: 0 gives a zero carry-in, 1 takes carry input bit 0, 2 takes carry input bit 1, 3 gives a constant 1
  - smu_a [12:11] and smu_b [10:9], the shift-unit operand sources
  - out_sel [8]: 0 selects the ALU result, 1 selects the shift-unit result
  - rd_a [7:6] and rd_b [5:4], the two register read addresses
  - wr_a [3:2], the register write address
  - wr_en [1], the register write enable
  - wr_src [0]: 0 writes the ALU result, 1 writes the shift-unit result
- R3: ADD gives a+b+ci mod 2^24, with carry bit 0 set to the carry-out and carry bit 1 set to 0. SUB gives a-b-ci mod 2^24, with carry bit 0 set to the borrow and carry bit 1 set to 0.
- R4: MUL gives the low 24 bits of a*b and a carry of 00.
- R5: CMP gives a-b mod 2^24 as data. Carry bit 0 is 1 when a<b (unsigned). Carry bit 1 is 1 when a==b. The carry-in select has no effect on CMP.
- R6: SHL shifts a left and SHR shifts a right (logical) by the full unsigned value of b; an amount of 24 or more gives 0. AND gives a&b. CONST gives imm zero-extended. When out_sel=1 the carry output is 00.
- R7: Operand source codes are 0 = neighbour input A, 1 = neighbour input B, 2 = register read port A, 3 = register read port B. Each of the four operands has its own select.
- R8: The register file is written at a clock edge when enable and wr_en are both 1. It is readable in the next cycle.
- R9: The pointer input is registered on every edge, whatever the enable. The slot it names sets the function for the following cycle.
- R10: A slot write takes effect at the edge where it is issued. If that slot is the active one, the output captured at that edge still reflects the old word, and the output captured at the next edge reflects the new word. A write to any other slot leaves the running function unchanged.
- R11: When enable is 0, the output register and the register file hold their values.
- R12: Reset clears the registered pointer, so the first edge after reset executes slot 0, whatever the pointer input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global enable for the output register and register-file writes |
| ctx_ptr_i | input | 6 | Context slot to execute next |
| cfg_we_i | input | 1 | Context memory write strobe |
| cfg_addr_i | input | 6 | Context slot to write |
| cfg_data_i | input | 31 | Configuration word to write |
| nb_a_i | input | 24 | Neighbour data input A |
| nb_b_i | input | 24 | Neighbour data input B |
| nb_cy_i | input | 2 | Neighbour carry input |
| res_d_o | output | 24 | Registered data result |
| res_cy_o | output | 2 | Registered carry result |

## Verification
A wrong registered pointer makes the output come from the wrong slot's function at the second edge after the pointer input changes. The reset and live-write tests catch this by placing distinct constants in neighbouring slots. A corrupted register-file entry stays hidden until a context reads it, and then it shows in the very next captured result. For that reason the bench writes, holds with enable low, and then reads through both read ports. Wrong carry handling shows in `res_cy_o` on the same edge as the data, so each arithmetic mode is checked at the wrap and equality boundaries.

// File: rtl/ctx_pe_pkg.sv
package ctx_pe_pkg;

    localparam int DATA_W  = 24;
    localparam int CY_W    = 2;
    localparam int RF_AW   = 2;
    localparam int RF_N    = 1 << RF_AW;
    localparam int IMM_W   = 8;
    localparam int N_OPND  = 4;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_MUL = 2'd2,
        ALU_CMP = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        SMU_SHL   = 2'd0,
        SMU_SHR   = 2'd1,
        SMU_AND   = 2'd2,
        SMU_CONST = 2'd3
    } smu_op_e;

    typedef enum logic [1:0] {
        SRC_NB_A = 2'd0,
        SRC_NB_B = 2'd1,
        SRC_RF_A = 2'd2,
        SRC_RF_B = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        CY_ZERO = 2'd0,
        CY_IN0  = 2'd1,
        CY_IN1  = 2'd2,
        CY_ONE  = 2'd3
    } cy_sel_e;

    typedef struct packed {
        logic [IMM_W-1:0] imm;
        alu_op_e          alu_op;
        smu_op_e          smu_op;
        src_e             alu_a;
        src_e             alu_b;
        cy_sel_e          alu_cy;
        src_e             smu_a;
        src_e             smu_b;
        logic             out_sel;
        logic [RF_AW-1:0] rd_a;
        logic [RF_AW-1:0] rd_b;
        logic [RF_AW-1:0] wr_a;
        logic             wr_en;
        logic             wr_src;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/ctx_pe_ctxmem.sv
module ctx_pe_ctxmem
    import ctx_pe_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  cfg_t          wdata_i,
    input  logic [AW-1:0] ptr_i,
    output logic [AW-1:0] ptr_q_o,
    output cfg_t          cfg_o
);

    cfg_t          slots [DEPTH];
    logic [AW-1:0] ptr_q;

    // Slot storage: no reset, written whenever strobed.
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            slots[waddr_i] <= wdata_i;
        end
    end

    // Registered pointer: one-clock context switch.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_i;
        end
    end

    assign ptr_q_o = ptr_q;
    assign cfg_o   = slots[ptr_q];

endmodule

// File: rtl/ctx_pe_regfile.sv
module ctx_pe_regfile
    import ctx_pe_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              we_i,
    input  logic [RF_AW-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [RF_AW-1:0]  raddr_a_i,
    input  logic [RF_AW-1:0]  raddr_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);

    logic [DATA_W-1:0] regs [RF_N];

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < RF_N; i++) begin
                regs[i] <= '0;
            end
        end else if (we_i) begin
            regs[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = regs[raddr_a_i];
    assign rdata_b_o = regs[raddr_b_i];

endmodule

// File: rtl/ctx_pe_alu.sv
module ctx_pe_alu
    import ctx_pe_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              ci_i,
    output logic [DATA_W-1:0] res_o,
    output logic [CY_W-1:0]   cy_o
);

    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_w;
    logic [DATA_W:0]   cmp_w;
    logic [DATA_W-1:0] prod_w;

    assign sum_w  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, ci_i};
    assign dif_w  = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, ci_i};
    assign cmp_w  = {1'b0, a_i} - {1'b0, b_i};
    assign prod_w = a_i * b_i;

    always_comb begin
        unique case (op_i)
            ALU_ADD: begin
                res_o = sum_w[DATA_W-1:0];
                cy_o  = {1'b0, sum_w[DATA_W]};
            end
            ALU_SUB: begin
                res_o = dif_w[DATA_W-1:0];
                cy_o  = {1'b0, dif_w[DATA_W]};
            end
            ALU_MUL: begin
                res_o = prod_w;
                cy_o  = '0;
            end
            ALU_CMP: begin
                res_o = cmp_w[DATA_W-1:0];
                cy_o  = {(a_i == b_i), cmp_w[DATA_W]};
            end
        endcase
    end

endmodule

// File: rtl/ctx_pe_smu.sv
module ctx_pe_smu
    import ctx_pe_pkg::*;
(
    input  smu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] res_o
);

    always_comb begin
        unique case (op_i)
            SMU_SHL:   res_o = a_i << b_i;
            SMU_SHR:   res_o = a_i >> b_i;
            SMU_AND:   res_o = a_i & b_i;
            SMU_CONST: res_o = {{(DATA_W-IMM_W){1'b0}}, imm_i};
        endcase
    end

endmodule

// File: rtl/ctx_pe.sv
module ctx_pe
    import ctx_pe_pkg::*;
#(
    parameter  int CTX_DEPTH = 64,
    localparam int PTR_W     = $clog2(CTX_DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              en_i,
    input  logic [PTR_W-1:0]  ctx_ptr_i,
    input  logic              cfg_we_i,
    input  logic [PTR_W-1:0]  cfg_addr_i,
    input  logic [CFG_W-1:0]  cfg_data_i,
    input  logic [DATA_W-1:0] nb_a_i,
    input  logic [DATA_W-1:0] nb_b_i,
    input  logic [CY_W-1:0]   nb_cy_i,
    output logic [DATA_W-1:0] res_d_o,
    output logic [CY_W-1:0]   res_cy_o
);

    localparam int OP_ALU_A = 0;
    localparam int OP_ALU_B = 1;
    localparam int OP_SMU_A = 2;
    localparam int OP_SMU_B = 3;

    cfg_t              cur_cfg;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] rf_a;
    logic [DATA_W-1:0] rf_b;
    logic [DATA_W-1:0] opnd [N_OPND];
    src_e              opnd_sel [N_OPND];
    logic              alu_ci;
    logic [DATA_W-1:0] alu_res;
    logic [CY_W-1:0]   alu_cy;
    logic [DATA_W-1:0] smu_res;
    logic [DATA_W-1:0] nxt_d;
    logic [CY_W-1:0]   nxt_cy;
    logic [DATA_W-1:0] rf_wdata;

    function automatic logic [DATA_W-1:0] pick_src(
        input src_e              s,
        input logic [DATA_W-1:0] na,
        input logic [DATA_W-1:0] nb,
        input logic [DATA_W-1:0] ra,
        input logic [DATA_W-1:0] rb
    );
        logic [DATA_W-1:0] v;
        unique case (s)
            SRC_NB_A: v = na;
            SRC_NB_B: v = nb;
            SRC_RF_A: v = ra;
            SRC_RF_B: v = rb;
        endcase
        return v;
    endfunction

    ctx_pe_ctxmem #(.DEPTH(CTX_DEPTH)) u_ctxmem (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .we_i    (cfg_we_i),
        .waddr_i (cfg_addr_i),
        .wdata_i (cfg_t'(cfg_data_i)),
        .ptr_i   (ctx_ptr_i),
        .ptr_q_o (ptr_q),
        .cfg_o   (cur_cfg)
    );

    ctx_pe_regfile u_rf (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .we_i      (en_i & cur_cfg.wr_en),
        .waddr_i   (cur_cfg.wr_a),
        .wdata_i   (rf_wdata),
        .raddr_a_i (cur_cfg.rd_a),
        .raddr_b_i (cur_cfg.rd_b),
        .rdata_a_o (rf_a),
        .rdata_b_o (rf_b)
    );

    assign opnd_sel[OP_ALU_A] = cur_cfg.alu_a;
    assign opnd_sel[OP_ALU_B] = cur_cfg.alu_b;
    assign opnd_sel[OP_SMU_A] = cur_cfg.smu_a;
    assign opnd_sel[OP_SMU_B] = cur_cfg.smu_b;

    // One independent operand multiplexer per functional-unit input.
    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        assign opnd[g] = pick_src(opnd_sel[g], nb_a_i, nb_b_i, rf_a, rf_b);
    end

    always_comb begin
        unique case (cur_cfg.alu_cy)
            CY_ZERO: alu_ci = 1'b0;
            CY_IN0:  alu_ci = nb_cy_i[0];
            CY_IN1:  alu_ci = nb_cy_i[1];
            CY_ONE:  alu_ci = 1'b1;
        endcase
    end

    ctx_pe_alu u_alu (
        .op_i  (cur_cfg.alu_op),
        .a_i   (opnd[OP_ALU_A]),
        .b_i   (opnd[OP_ALU_B]),
        .ci_i  (alu_ci),
        .res_o (alu_res),
        .cy_o  (alu_cy)
    );

    ctx_pe_smu u_smu (
        .op_i  (cur_cfg.smu_op),
        .a_i   (opnd[OP_SMU_A]),
        .b_i   (opnd[OP_SMU_B]),
        .imm_i (cur_cfg.imm),
        .res_o (smu_res)
    );

    assign rf_wdata = cur_cfg.wr_src ? smu_res : alu_res;

    always_comb begin
        if (cur_cfg.out_sel) begin
            nxt_d  = smu_res;
            nxt_cy = '0;
        end else begin
            nxt_d  = alu_res;
            nxt_cy = alu_cy;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            res_d_o  <= '0;
            res_cy_o <= '0;
        end else if (en_i) begin
            res_d_o  <= nxt_d;
            res_cy_o <= nxt_cy;
        end
    end

endmodule

// File: rtl/ctx_pe_chk.sv
module ctx_pe_chk
    import ctx_pe_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [PTR_W-1:0]  ptr_in,
    input logic [PTR_W-1:0]  ptr_q,
    input logic              use_smu,
    input alu_op_e           alu_op,
    input logic [DATA_W-1:0] res_d,
    input logic [CY_W-1:0]   res_cy
);

    a_r1_reset_clears_output: assert property (@(posedge clk)
        $rose(rst_n) |-> (res_d == '0 && res_cy == '0));

    a_r12_reset_clears_pointer: assert property (@(posedge clk)
        $rose(rst_n) |-> ptr_q == '0);

    a_r9_pointer_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ptr_q == $past(ptr_in));

    a_r11_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(res_d) && $stable(res_cy)));

    a_r3_arith_carry_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !use_smu && (alu_op == ALU_ADD || alu_op == ALU_SUB)) |=> !res_cy[1]);

    a_r4_mul_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !use_smu && alu_op == ALU_MUL) |=> res_cy == '0);

    a_r5_cmp_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !use_smu && alu_op == ALU_CMP) |=> $countones(res_cy) <= 1);

    a_r6_shift_unit_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (en && use_smu) |=> res_cy == '0);

endmodule

bind ctx_pe ctx_pe_chk #(.PTR_W(PTR_W)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_n_i),
    .en      (en_i),
    .ptr_in  (ctx_ptr_i),
    .ptr_q   (ptr_q),
    .use_smu (cur_cfg.out_sel),
    .alu_op  (cur_cfg.alu_op),
    .res_d   (res_d_o),
    .res_cy  (res_cy_o)
);

// File: tb/ctx_pe_test.sv
`timescale 1ns/1ps
module ctx_pe_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [5:0]  ptr = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [30:0] cfg_data = '0;
    logic [23:0] nb_a = '0;
    logic [23:0] nb_b = '0;
    logic [1:0]  nb_cy = '0;
    logic [23:0] res_d;
    logic [1:0]  res_cy;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ctx_pe uut (
        .clk_i      (clk),
        .rst_n_i    (rst_n),
        .en_i       (en),
        .ctx_ptr_i  (ptr),
        .cfg_we_i   (cfg_we),
        .cfg_addr_i (cfg_addr),
        .cfg_data_i (cfg_data),
        .nb_a_i     (nb_a),
        .nb_b_i     (nb_b),
        .nb_cy_i    (nb_cy),
        .res_d_o    (res_d),
        .res_cy_o   (res_cy)
    );

    // Word layout from R2, MSB first.
    function automatic logic [30:0] mk(
        input logic [7:0] imm, input logic [1:0] aop, input logic [1:0] sop,
        input logic [1:0] aa,  input logic [1:0] ab,  input logic [1:0] acy,
        input logic [1:0] sa,  input logic [1:0] sb,  input logic osel,
        input logic [1:0] ra,  input logic [1:0] rb,  input logic [1:0] wa,
        input logic we, input logic ws);
        return {imm, aop, sop, aa, ab, acy, sa, sb, osel, ra, rb, wa, we, ws};
    endfunction

    typedef struct packed {
        logic [1:0]  aop;
        logic [1:0]  sop;
        logic        osel;
        logic [1:0]  acy;
        logic [7:0]  imm;
        logic [23:0] a;
        logic [23:0] b;
        logic [1:0]  cin;
        logic [23:0] ed;
        logic [1:0]  ec;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b0, 2'd0, 8'h00, 24'h000010, 24'h000020, 2'b11, 24'h000030, 2'b00},
        '{2'd0, 2'd0, 1'b0, 2'd0, 8'h00, 24'hFFFFFF, 24'h000001, 2'b00, 24'h000000, 2'b01},
        '{2'd0, 2'd0, 1'b0, 2'd1, 8'h00, 24'h000005, 24'h000006, 2'b01, 24'h00000C, 2'b00},
        '{2'd0, 2'd0, 1'b0, 2'd2, 8'h00, 24'h000005, 24'h000006, 2'b10, 24'h00000C, 2'b00},
        '{2'd0, 2'd0, 1'b0, 2'd1, 8'h00, 24'h000005, 24'h000006, 2'b10, 24'h00000B, 2'b00},
        '{2'd0, 2'd0, 1'b0, 2'd3, 8'h00, 24'hFFFFFF, 24'h000000, 2'b00, 24'h000000, 2'b01},
        '{2'd1, 2'd0, 1'b0, 2'd0, 8'h00, 24'h000010, 24'h000003, 2'b00, 24'h00000D, 2'b00},
        '{2'd1, 2'd0, 1'b0, 2'd0, 8'h00, 24'h000003, 24'h000010, 2'b00, 24'hFFFFF3, 2'b01},
        '{2'd1, 2'd0, 1'b0, 2'd1, 8'h00, 24'h000010, 24'h000003, 2'b01, 24'h00000C, 2'b00},
        '{2'd1, 2'd0, 1'b0, 2'd3, 8'h00, 24'h000010, 24'h000003, 2'b00, 24'h00000C, 2'b00},
        '{2'd2, 2'd0, 1'b0, 2'd0, 8'h00, 24'h001000, 24'h001000, 2'b00, 24'h000000, 2'b00},
        '{2'd2, 2'd0, 1'b0, 2'd0, 8'h00, 24'h000123, 24'h000010, 2'b00, 24'h001230, 2'b00},
        '{2'd3, 2'd0, 1'b0, 2'd3, 8'h00, 24'h000005, 24'h000009, 2'b11, 24'hFFFFFC, 2'b01},
        '{2'd3, 2'd0, 1'b0, 2'd0, 8'h00, 24'h000009, 24'h000009, 2'b00, 24'h000000, 2'b10},
        '{2'd3, 2'd0, 1'b0, 2'd0, 8'h00, 24'h800000, 24'h000001, 2'b00, 24'h7FFFFF, 2'b00},
        '{2'd0, 2'd0, 1'b1, 2'd0, 8'h00, 24'h000001, 24'h000017, 2'b00, 24'h800000, 2'b00},
        '{2'd0, 2'd1, 1'b1, 2'd0, 8'h00, 24'h800000, 24'h000004, 2'b00, 24'h080000, 2'b00},
        '{2'd0, 2'd0, 1'b1, 2'd0, 8'h00, 24'h000001, 24'h000018, 2'b00, 24'h000000, 2'b00},
        '{2'd0, 2'd2, 1'b1, 2'd0, 8'h00, 24'hF0F0F0, 24'h00FFFF, 2'b00, 24'h00F0F0, 2'b00},
        '{2'd0, 2'd3, 1'b1, 2'd0, 8'hA5, 24'h123456, 24'h654321, 2'b00, 24'h0000A5, 2'b00}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [5:0] slot, input logic [30:0] w);
        cfg_we   = 1'b1;
        cfg_addr = slot;
        cfg_data = w;
        tick();
        cfg_we   = 1'b0;
    endtask

    task automatic chk(input string req, input logic [23:0] ed, input logic [1:0] ec);
        n_chk++;
        if (res_d !== ed || res_cy !== ec) begin
            n_fail++;
            $display("FAIL %s: got d=%h c=%b, expected d=%h c=%b", req, res_d, res_cy, ed, ec);
        end
    endtask

    function automatic void summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        // Loading slots during reset: slot 0 and slot 5 hold distinct constants.
        load(6'd0, mk(8'h11, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        load(6'd5, mk(8'h55, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        load(6'd2, mk(8'h00, 2'd0, 2'd0, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 2'd1, 2'd3, 2'd0, 1'b0, 1'b0));
        ptr  = 6'd5;
        en   = 1'b1;
        nb_a = 24'h00ABCD;
        tick();
        chk("R1 reset output", 24'h0, 2'b00);

        // R12: first edge after reset runs slot 0; R9: next edge runs slot 5.
        rst_n = 1'b1;
        tick();
        chk("R12 pointer cleared", 24'h000011, 2'b00);
        tick();
        chk("R9 switch to slot 5", 24'h000055, 2'b00);

        // R1: register file reads zero after reset (ports A and B).
        ptr = 6'd2;
        tick();
        tick();
        chk("R1 regfile zero", 24'h0, 2'b00);

        // Vector table: R2 layout with R3 R4 R5 R6 R7 operations.
        for (int i = 0; i < NV; i++) begin
            load(6'(20 + i), mk(VECS[i].imm, VECS[i].aop, VECS[i].sop, 2'd0, 2'd1, VECS[i].acy,
                                2'd0, 2'd1, VECS[i].osel, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0));
            ptr   = 6'(20 + i);
            nb_a  = VECS[i].a;
            nb_b  = VECS[i].b;
            nb_cy = VECS[i].cin;
            tick();
            tick();
            chk($sformatf("R2 vector %0d", i), VECS[i].ed, VECS[i].ec);
        end
        nb_cy = 2'b00;

        // R8: write RF[2] with a constant via the shift unit, then read it through port A.
        load(6'd10, mk(8'h3C, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1));
        load(6'd11, mk(8'h00, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0));
        load(6'd12, mk(8'h77, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1));
        load(6'd16, mk(8'h00, 2'd1, 2'd0, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0));
        ptr  = 6'd10;
        nb_a = 24'h000004;
        tick();
        tick();
        chk("R8 const written", 24'h00003C, 2'b00);
        ptr = 6'd11;
        tick();
        tick();
        chk("R8 regfile port A read", 24'h000040, 2'b00);

        // R7: register read port B as the ALU B operand, neighbour B as A.
        ptr  = 6'd16;
        nb_b = 24'h000100;
        tick();
        tick();
        chk("R7 regfile port B operand", 24'h0000C4, 2'b00);

        // R11: disabled cycles hold the output and block register writes.
        en   = 1'b0;
        ptr  = 6'd12;
        nb_b = 24'h000999;
        tick();
        tick();
        chk("R11 output held", 24'h0000C4, 2'b00);
        ptr = 6'd11;
        tick();
        en = 1'b1;
        tick();
        chk("R11 regfile held", 24'h000040, 2'b00);

        // R10: rewrite the running slot, then a different slot.
        load(6'd13, mk(8'h21, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        ptr = 6'd13;
        tick();
        tick();
        chk("R10 before rewrite", 24'h000021, 2'b00);
        load(6'd13, mk(8'h42, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        chk("R10 old word at write edge", 24'h000021, 2'b00);
        tick();
        chk("R10 new word next edge", 24'h000042, 2'b00);
        load(6'd14, mk(8'h99, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0));
        tick();
        chk("R10 other slot write no effect", 24'h000042, 2'b00);

        summary();
        $finish;
    end

endmodule